// File: doc/BRIEF.md
# Predicting Fetch Front End

This block produces the instruction fetch address every cycle and forwards the fetched instruction words to a decoder through a small FIFO. Each FIFO entry holds the fetch PC, the PC that fetch followed next, and the instruction word. The instruction memory is a synchronous read port: the word for the address shown in one cycle comes back in the next cycle.

Fetch uses two predictors. A global-history pattern predictor holds 2-bit counters, indexed by the XOR of PC bits [9:2] with an 8-bit outcome history. A direct-mapped, tagged target table supplies the taken target. The next fetch address is the table target only when the table hits and the counter votes taken. Otherwise fetch goes on to PC+4.

Each branch result from the execute stage trains both structures. A result that disagrees with the path fetch followed raises a mispredict flag and moves fetch to the correct path. Trap and return vectors also move fetch. Any redirect empties the FIFO and drops the word still in flight. A stall input freezes fetch, and the word in flight is kept.

Top module: `pfe_fetch_top`

## Requirements
- R1: While reset is asserted and right after it is released, the fetch address equals RESET_PC, the buffer is empty, the full flag is low and the mispredict flag is low.
- R2: Without a prediction or redirect, each fetch address that is taken into the pipeline is followed by that address plus 4. A buffer entry presents {pc, next pc, the word the memory returned for pc}, and entries come out in fetch order.
- R3: The pattern counters are 2-bit saturating counters that reset to 01, and bit 1 set means taken. The counter index is PC[9:2] XOR the history. On every valid result, the counter at res_pc[9:2] XOR the current history steps toward the outcome. The history then shifts left, with the outcome entering bit 0.
- R4: The target table has 32 entries, indexed by PC[6:2] and tagged with PC[31:7]. An entry is written with the result target on every valid result that was taken. The next fetch address is the stored target only when the tag matches and the counter votes taken.
- R5: Redirect priority is trap vector, then return vector, then the corrected branch path, then the predicted target, then PC+4. A redirect sets the fetch address on the next edge, overrides a stall, and removes all buffered and in-flight entries.
- R6: mispred_o is high in the same cycle as res_valid_i when res_pred_i (1 = fetch followed the taken path) differs from res_taken_i. The corrected path is res_target_i if the branch was taken and res_pc_i+4 if it was not.
- R7: The full flag is high exactly when IB_DEPTH entries are buffered. While it is high no entry is written, and no fetched word is lost or duplicated.
- R8: While stall_i is high and no redirect occurs, the fetch address holds and the buffer takes no writes. The word already in flight enters the buffer later with its correct content.
- R9: rd_en_i removes the head entry only when the buffer is non-empty. rd_en_i on an empty buffer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze fetch and buffer writes |
| imem_addr_o | output | 32 | Fetch address to instruction memory |
| imem_data_i | input | 32 | Word for the previous cycle's address |
| rd_en_i | input | 1 | Decoder takes the head entry |
| ib_valid_o | output | 1 | Buffer head is valid |
| ib_pc_o | output | 32 | Head entry PC |
| ib_npc_o | output | 32 | Head entry next PC followed by fetch |
| ib_instr_o | output | 32 | Head entry instruction word |
| ib_full_o | output | 1 | Buffer is full |
| res_valid_i | input | 1 | Branch result valid |
| res_pc_i | input | 32 | Resolved branch PC |
| res_target_i | input | 32 | Resolved taken target |
| res_taken_i | input | 1 | Resolved outcome |
| res_pred_i | input | 1 | Fetch followed the taken path |
| mispred_o | output | 1 | Result disagrees with the path followed |
| trap_i | input | 1 | Trap redirect |
| trap_vec_i | input | 32 | Trap vector |
| mret_i | input | 1 | Return-from-trap redirect |
| mret_vec_i | input | 32 | Return vector |

## Verification
A wrong counter, history bit or table entry does not show at the ports until fetch next reaches the affected branch PC. The error then appears as a fetch address that differs from the model one cycle after that PC is fetched. The bench therefore trains a branch and fetches it again later under a fixed history. A FIFO pointer or count error shows at once in the head fields or the full flag. A lost held word shows only when a stall is released, so the bench stalls with a word in flight.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t       pc;
    addr_t       npc;
    logic [31:0] instr;
  } fetch_pkt_t;

  // sequential successor of a fetch address
  function automatic addr_t seq_pc(input addr_t pc);
    return pc + 32'd4;
  endfunction

  // saturating 2-bit counter step toward the outcome
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/pfe_gshare.sv
module pfe_gshare #(
  parameter int GHR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GHR_W-1:0] look_bits_i,
  output logic             taken_o,
  input  logic             upd_i,
  input  logic [GHR_W-1:0] upd_bits_i,
  input  logic             upd_taken_i
);
  import pfe_pkg::*;
  localparam int N_CTR = 1 << GHR_W;

  logic [GHR_W-1:0] ghr_q;
  logic [1:0]       ctr_q [N_CTR];
  logic [GHR_W-1:0] look_idx, upd_idx;

  function automatic logic [GHR_W-1:0] gs_index(input logic [GHR_W-1:0] pcb,
                                                input logic [GHR_W-1:0] h);
    return pcb ^ h;
  endfunction

  assign look_idx = gs_index(look_bits_i, ghr_q);
  assign upd_idx  = gs_index(upd_bits_i, ghr_q);
  assign taken_o  = ctr_q[look_idx][1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr_q <= '0;
      for (int i = 0; i < N_CTR; i++) ctr_q[i] <= 2'b01;
    end else if (upd_i) begin
      ghr_q          <= {ghr_q[GHR_W-2:0], upd_taken_i};
      ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_taken_i);
    end
  end

  // R3: outcome enters history bit 0
  p_ghr_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> ghr_q[0] == $past(upd_taken_i));
  // R3: a saturated counter stays saturated on a further taken outcome
  p_ctr_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && upd_taken_i && ctr_q[upd_idx] == 2'b11) |=> ctr_q[$past(upd_idx)] == 2'b11);
endmodule

// File: rtl/pfe_btb.sv
module pfe_btb #(
  parameter int IDX_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [29:0]    look_word_i,
  output logic           hit_o,
  output pfe_pkg::addr_t tgt_o,
  input  logic           wr_i,
  input  logic [29:0]    wr_word_i,
  input  pfe_pkg::addr_t wr_tgt_i
);
  import pfe_pkg::*;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = 30 - IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  addr_t              tgt_q [ENTRIES];
  logic [IDX_W-1:0]   l_idx, w_idx;
  logic [TAG_W-1:0]   l_tag, w_tag;

  assign l_idx = look_word_i[IDX_W-1:0];
  assign l_tag = look_word_i[29:IDX_W];
  assign w_idx = wr_word_i[IDX_W-1:0];
  assign w_tag = wr_word_i[29:IDX_W];
  assign hit_o = vld_q[l_idx] && (tag_q[l_idx] == l_tag);
  assign tgt_o = tgt_q[l_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_i) vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_i) begin
      tag_q[w_idx] <= w_tag;
      tgt_q[w_idx] <= wr_tgt_i;
    end
  end

  // R4: a written slot is valid and holds the written tag
  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (vld_q[$past(w_idx)] && tag_q[$past(w_idx)] == $past(w_tag)));
endmodule

// File: rtl/pfe_ibuf.sv
module pfe_ibuf #(
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic                push_i,
  input  pfe_pkg::fetch_pkt_t pkt_i,
  input  logic                pop_i,
  output pfe_pkg::fetch_pkt_t pkt_o,
  output logic                valid_o,
  output logic                full_o
);
  import pfe_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  fetch_pkt_t       mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && valid_o;
  assign pkt_o   = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_next(wr_q);
      if (do_pop) rd_q <= ptr_next(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !flush_i) mem_q[wr_q] <= pkt_i;
  end

  // R7: never written while full
  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R7: occupancy bounded by depth
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R9: a read of an empty buffer leaves it empty
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !push_i) |=> !valid_o);
endmodule

// File: rtl/pfe_fetch_top.sv
module pfe_fetch_top #(
  parameter logic [31:0] RESET_PC  = 32'h0000_0000,
  parameter int          GHR_W     = 8,
  parameter int          BTB_IDX_W = 5,
  parameter int          IB_DEPTH  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall_i,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_data_i,
  input  logic        rd_en_i,
  output logic        ib_valid_o,
  output logic [31:0] ib_pc_o,
  output logic [31:0] ib_npc_o,
  output logic [31:0] ib_instr_o,
  output logic        ib_full_o,
  input  logic        res_valid_i,
  input  logic [31:0] res_pc_i,
  input  logic [31:0] res_target_i,
  input  logic        res_taken_i,
  input  logic        res_pred_i,
  output logic        mispred_o,
  input  logic        trap_i,
  input  logic [31:0] trap_vec_i,
  input  logic        mret_i,
  input  logic [31:0] mret_vec_i
);
  import pfe_pkg::*;

  // fetch state
  addr_t       pc_q, f2_pc_q, f2_npc_q;
  logic        f2_v_q, f2_fresh_q;
  logic [31:0] f2_hold_q, f2_instr;

  // named internal events
  logic  pred_taken, btb_hit, take_pred;
  addr_t btb_tgt, pred_npc, fix_tgt, redir_tgt;
  logic  redir_any, ib_push, f2_take;
  fetch_pkt_t push_pkt, head_pkt;

  pfe_gshare #(.GHR_W(GHR_W)) u_gshare (
    .clk         (clk),
    .rst_n       (rst_n),
    .look_bits_i (pc_q[GHR_W+1:2]),
    .taken_o     (pred_taken),
    .upd_i       (res_valid_i),
    .upd_bits_i  (res_pc_i[GHR_W+1:2]),
    .upd_taken_i (res_taken_i)
  );

  pfe_btb #(.IDX_W(BTB_IDX_W)) u_btb (
    .clk         (clk),
    .rst_n       (rst_n),
    .look_word_i (pc_q[31:2]),
    .hit_o       (btb_hit),
    .tgt_o       (btb_tgt),
    .wr_i        (res_valid_i && res_taken_i),
    .wr_word_i   (res_pc_i[31:2]),
    .wr_tgt_i    (res_target_i)
  );

  // prediction and PC select
  assign take_pred = pred_taken && btb_hit;
  assign pred_npc  = take_pred ? btb_tgt : seq_pc(pc_q);
  assign mispred_o = res_valid_i && (res_pred_i != res_taken_i);
  assign fix_tgt   = res_taken_i ? res_target_i : seq_pc(res_pc_i);
  assign redir_any = trap_i || mret_i || mispred_o;
  assign redir_tgt = trap_i ? trap_vec_i : (mret_i ? mret_vec_i : fix_tgt);

  // second stage: word arrives one cycle after its address
  assign f2_instr  = f2_fresh_q ? imem_data_i : f2_hold_q;
  assign ib_push   = f2_v_q && !stall_i && !ib_full_o && !redir_any;
  assign f2_take   = !stall_i && (!f2_v_q || ib_push) && !redir_any;
  assign push_pkt  = '{pc: f2_pc_q, npc: f2_npc_q, instr: f2_instr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      f2_v_q     <= 1'b0;
      f2_fresh_q <= 1'b0;
      f2_pc_q    <= '0;
      f2_npc_q   <= '0;
      f2_hold_q  <= '0;
    end else if (redir_any) begin
      pc_q       <= redir_tgt;
      f2_v_q     <= 1'b0;
      f2_fresh_q <= 1'b0;
    end else if (f2_take) begin
      pc_q       <= pred_npc;
      f2_v_q     <= 1'b1;
      f2_fresh_q <= 1'b1;
      f2_pc_q    <= pc_q;
      f2_npc_q   <= pred_npc;
    end else begin
      f2_fresh_q <= 1'b0;
      f2_hold_q  <= f2_instr;
    end
  end

  pfe_ibuf #(.DEPTH(IB_DEPTH)) u_ibuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (redir_any),
    .push_i  (ib_push),
    .pkt_i   (push_pkt),
    .pop_i   (rd_en_i),
    .pkt_o   (head_pkt),
    .valid_o (ib_valid_o),
    .full_o  (ib_full_o)
  );

  assign imem_addr_o = pc_q;
  assign ib_pc_o     = head_pkt.pc;
  assign ib_npc_o    = head_pkt.npc;
  assign ib_instr_o  = head_pkt.instr;

  // R5: any redirect lands on its target and empties the buffer
  p_redirect_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_any |=> imem_addr_o == $past(redir_tgt));
  p_redirect_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_any |=> !ib_valid_o);
  // R5: a trap wins over every other source
  p_trap_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> imem_addr_o == $past(trap_vec_i));
  // R8: stall without redirect holds the fetch address
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !redir_any) |=> $stable(imem_addr_o));
  // R2: an unpredicted advance steps by 4
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_take && !take_pred) |=> imem_addr_o == $past(imem_addr_o) + 32'd4);
endmodule

// File: tb/pfe_fetch_top_tb.sv
module pfe_fetch_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam logic [31:0] RST_PC = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] imem_addr_o, imem_data_i;
  logic        ib_valid_o, ib_full_o, mispred_o;
  logic [31:0] ib_pc_o, ib_npc_o, ib_instr_o;
  logic        res_valid_i = 1'b0, res_taken_i = 1'b0, res_pred_i = 1'b0;
  logic [31:0] res_pc_i = '0, res_target_i = '0;
  logic        trap_i = 1'b0, mret_i = 1'b0;
  logic [31:0] trap_vec_i = '0, mret_vec_i = '0;

  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfe_fetch_top u_dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .imem_addr_o(imem_addr_o),
    .imem_data_i(imem_data_i), .rd_en_i(rd_en_i), .ib_valid_o(ib_valid_o),
    .ib_pc_o(ib_pc_o), .ib_npc_o(ib_npc_o), .ib_instr_o(ib_instr_o),
    .ib_full_o(ib_full_o), .res_valid_i(res_valid_i), .res_pc_i(res_pc_i),
    .res_target_i(res_target_i), .res_taken_i(res_taken_i), .res_pred_i(res_pred_i),
    .mispred_o(mispred_o), .trap_i(trap_i), .trap_vec_i(trap_vec_i),
    .mret_i(mret_i), .mret_vec_i(mret_vec_i)
  );

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  // synchronous instruction memory
  always @(posedge clk) imem_data_i <= memfn(imem_addr_o);

  // ---------------- reference model ----------------
  logic [31:0] m_pc, m_f2pc, m_f2npc;
  bit          m_f2v;
  logic [31:0] qpc[$], qnpc[$];
  int          mctr[256];
  logic [7:0]  mghr;
  bit          mbv[32];
  logic [24:0] mbtag[32];
  logic [31:0] mbtgt[32];

  task automatic model_reset();
    m_pc = RST_PC; m_f2v = 0; qpc.delete(); qnpc.delete(); mghr = '0;
    for (int i = 0; i < 256; i++) mctr[i] = 1;
    for (int i = 0; i < 32; i++) mbv[i] = 0;
  endtask

  task automatic model_step();
    bit full, mp, redir, hit, pop, push;
    logic [31:0] rt, nxt;
    int gi, bi, ui;
    full  = (qpc.size() == DEPTH);
    mp    = res_valid_i && (res_pred_i != res_taken_i);
    redir = trap_i || mret_i || mp;
    rt    = trap_i ? trap_vec_i : (mret_i ? mret_vec_i :
            (res_taken_i ? res_target_i : res_pc_i + 32'd4));
    gi  = int'(m_pc[9:2] ^ mghr);
    bi  = int'(m_pc[6:2]);
    hit = mbv[bi] && (mbtag[bi] == m_pc[31:7]);
    nxt = (hit && mctr[gi] >= 2) ? mbtgt[bi] : m_pc + 32'd4;
    if (res_valid_i) begin
      ui = int'(res_pc_i[9:2] ^ mghr);
      if (res_taken_i && mctr[ui] < 3) mctr[ui]++;
      if (!res_taken_i && mctr[ui] > 0) mctr[ui]--;
      mghr = {mghr[6:0], res_taken_i};
      if (res_taken_i) begin
        mbv[int'(res_pc_i[6:2])] = 1;
        mbtag[int'(res_pc_i[6:2])] = res_pc_i[31:7];
        mbtgt[int'(res_pc_i[6:2])] = res_target_i;
      end
    end
    if (redir) begin
      qpc.delete(); qnpc.delete(); m_f2v = 0; m_pc = rt;
    end else begin
      pop  = rd_en_i && qpc.size() > 0;
      push = m_f2v && !stall_i && !full;
      if (pop) begin void'(qpc.pop_front()); void'(qnpc.pop_front()); end
      if (push) begin qpc.push_back(m_f2pc); qnpc.push_back(m_f2npc); end
      if (!stall_i && (!m_f2v || push)) begin
        m_f2pc = m_pc; m_f2npc = nxt; m_f2v = 1; m_pc = nxt;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ev;
    ev = qpc.size() > 0;
    chk("R2 R3 R4 R5 fetch address", imem_addr_o, m_pc);
    chk("R9 head valid", 32'(ib_valid_o), 32'(ev));
    chk("R7 full flag", 32'(ib_full_o), 32'(qpc.size() == DEPTH));
    chk("R6 mispredict", 32'(mispred_o), 32'(res_valid_i && (res_pred_i != res_taken_i)));
    if (ev) begin
      chk("R2 entry pc", ib_pc_o, qpc[0]);
      chk("R2 entry next pc", ib_npc_o, qnpc[0]);
      chk("R8 entry word", ib_instr_o, memfn(qpc[0]));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic clear_inputs();
    stall_i = 0; rd_en_i = 0; res_valid_i = 0; res_taken_i = 0; res_pred_i = 0;
    trap_i = 0; mret_i = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  localparam logic [31:0] XB = 32'h0000_0100;
  localparam logic [31:0] XT = 32'h0000_0800;

  initial begin
    logic [31:0] held;
    logic [31:0] expc[4];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset address", imem_addr_o, RST_PC);
    chk("R1 reset empty", 32'(ib_valid_o), 32'd0);
    chk("R1 reset not full", 32'(ib_full_o), 32'd0);
    chk("R1 reset no mispredict", 32'(mispred_o), 32'd0);

    // R2 sequential streaming
    rd_en_i = 1;
    repeat (12) tick();

    // R7 fill with no reads
    rd_en_i = 0;
    repeat (8) tick();
    chk("R7 full after fill", 32'(ib_full_o), 32'd1);
    held = imem_addr_o;
    tick();
    chk("R7 fetch held while full", imem_addr_o, held);
    rd_en_i = 1;
    repeat (6) tick();

    // R8 stall with a word in flight
    stall_i = 1; rd_en_i = 0;
    held = imem_addr_o;
    repeat (3) tick();
    chk("R8 stall holds address", imem_addr_o, held);
    stall_i = 0; rd_en_i = 1;
    repeat (8) tick();

    // R3 R4 training of one taken branch while stalled
    stall_i = 1; rd_en_i = 0;
    res_valid_i = 1; res_pc_i = XB; res_target_i = XT; res_taken_i = 1; res_pred_i = 1;
    repeat (10) tick();
    clear_inputs();
    trap_i = 1; trap_vec_i = XB - 32'd8;
    tick();
    chk("R5 trap target", imem_addr_o, XB - 32'd8);
    chk("R5 trap flush", 32'(ib_valid_o), 32'd0);
    trap_i = 0;
    repeat (8) tick();
    chk("R7 full after refill", 32'(ib_full_o), 32'd1);
    expc[0] = XB - 32'd8; expc[1] = XB - 32'd4; expc[2] = XB; expc[3] = XT;
    for (int k = 0; k < 4; k++) begin
      chk("R4 predicted stream pc", ib_pc_o, expc[k]);
      if (k == 2) chk("R4 taken target followed", ib_npc_o, XT);
      if (k == 1) chk("R3 untrained not taken", ib_npc_o, XB);
      rd_en_i = 1; tick(); rd_en_i = 0;
    end

    // R5 R6 priorities
    res_valid_i = 1; res_pc_i = 32'h40; res_target_i = 32'h300; res_taken_i = 1; res_pred_i = 0;
    trap_i = 1; trap_vec_i = 32'h500; mret_i = 1; mret_vec_i = 32'h600;
    #1 chk("R6 mispredict combinational", 32'(mispred_o), 32'd1);
    tick();
    chk("R5 trap over return and branch", imem_addr_o, 32'h500);
    trap_i = 0;
    tick();
    chk("R5 return over branch", imem_addr_o, 32'h600);
    mret_i = 0; res_taken_i = 0; res_pred_i = 1;
    tick();
    chk("R6 not-taken correction", imem_addr_o, 32'h44);
    res_valid_i = 0;
    res_pred_i = 1; res_taken_i = 1;
    #1 chk("R6 no flag without valid", 32'(mispred_o), 32'd0);

    // R9 read of empty buffer
    clear_inputs();
    stall_i = 1; rd_en_i = 1;
    repeat (3) tick();
    chk("R9 empty read ignored", 32'(ib_valid_o), 32'd0);
    stall_i = 0; rd_en_i = 0;
    repeat (4) tick();

    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      stall_i     = (r[2:0] == 3'd0);
      rd_en_i     = r[3] | r[4];
      res_valid_i = (r[8:5] == 4'd0);
      res_pc_i    = {22'd0, r[17:10], 2'b00};
      res_target_i= {22'd0, r[27:20], 2'b00};
      res_taken_i = r[18];
      res_pred_i  = r[18] ^ (r[19] & r[28]);
      trap_i      = (r[31:29] == 3'd0) && r[9];
      trap_vec_i  = {24'd0, r[15:10], 2'b00};
      mret_i      = (r[31:29] == 3'd1) && r[9];
      mret_vec_i  = {24'd0, r[21:16], 2'b00};
      tick();
    end
    clear_inputs();
    tick();
    done = 1;
    finish_run();
  end
endmodule